// File: doc/BRIEF.md
# Saturating Scale-and-Offset Unit

This block multiplies a signed sample by a signed scale coefficient, rounds the product back to sample precision, adds a signed integer offset, and clips the result to the sample range. It is the usual gain-and-bias stage placed in front of a converter or between two processing stages. With the default setting the scale is a signed fraction of full scale: the largest positive code is just under +1, and the most negative code means exactly -1. A compile-time shift `SHIFT` multiplies the scale range by 2^SHIFT. With `SHIFT=4` and a 16-bit scale, the coefficient spans -16 to +16.

The product keeps `SCALE_W-1-SHIFT` fractional bits. These are removed by adding half an LSB and then discarding them, which rounds half up. The offset is counted in output LSBs and is added to the rounded product. Every intermediate value carries enough guard bits to stay exact. The full-precision sum is then compared with the output limits, so the result saturates instead of wrapping. A sample presented with `in_valid` appears on `z_out` one clock later, with `out_valid` set for that one cycle.

Top module: `scale_offset_sat`

## Requirements
- R1: For a registered sample, `z_out` equals floor((x*scale + 2^(F-1)) / 2^F) + offset, where F = SCALE_W-1-SHIFT. With the defaults (F=15), scale code -32768 means -1 and code 16384 means 0.5, so x=16384 with scale=16384 gives 8192.
- R2: Rounding is half up. A fractional part of exactly one half moves the result toward plus infinity: x=1 gives 1, x=-1 gives 0 and x=-3 gives -1 with scale 16384. A fraction below one half is dropped: x=1 with scale=8191 gives 0.
- R3: When the exact result is greater than 2^(DATA_W-1)-1, `z_out` is 2^(DATA_W-1)-1 (32767 by default). This covers x=-32768 with scale=-32768, whose exact value is 32768.
- R4: When the exact result is less than -2^(DATA_W-1), `z_out` is -2^(DATA_W-1) (-32768). An exact result of -32768 is passed through unchanged.
- R5: The offset is a plain integer in output LSBs with no fractional weighting: x=0 with offset=-123 gives -123.
- R6: The result of a sample presented with `in_valid=1` at a rising edge appears on `z_out` after that edge. `out_valid` is `in_valid` delayed by exactly one cycle.
- R7: While `in_valid` is 0, `z_out` holds its last value, whatever `x_in`, `scale_in` and `offset_in` do.
- R8: A synchronous active-high `rst` clears `z_out` to 0 and `out_valid` to 0 at the next rising edge. It overrides `in_valid`.
- R9: `SHIFT=N` multiplies the scale range by 2^N. With N=4, scale code 2048 means 1.0, so x=100 gives 100. In the same setting, x=1000 with scale=32767 gives 16000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operands in this cycle |
| x_in | input | DATA_W | Signed sample |
| scale_in | input | SCALE_W | Signed scale coefficient, a fraction scaled by 2^SHIFT |
| offset_in | input | OFF_W | Signed offset in output LSBs |
| z_out | output | DATA_W | Rounded and saturated result, registered |
| out_valid | output | 1 | Marks the cycle in which a new result is on z_out |

## Verification
The properties assume that `rst` is high at the first clock edge. They also assume that `in_valid` and the operands are steady around each rising edge, and never X or Z while `rst` is low. The saturation properties take the adder's clip decision as given and check only that the register delivers the matching limit one cycle later. The bench drives every input on the falling edge and raises reset from time zero. It keeps the operands defined throughout, including the idle cycles in which it changes them on purpose to check the hold behaviour.

// File: rtl/sos_pkg.sv
package sos_pkg;

    // Clip decision made on the full-precision sum
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HI   = 2'd1,
        SAT_LO   = 2'd2
    } sat_kind_e;

    // Fractional product bits that are discarded for a given scale width and range shift
    function automatic int frac_bits(input int scale_w, input int shift);
        return scale_w - 1 - shift;
    endfunction

    // Width of a signed sum able to hold two signed operands exactly
    function automatic int sum_width(input int a_w, input int b_w);
        return ((a_w > b_w) ? a_w : b_w) + 1;
    endfunction

endpackage

// File: rtl/sos_round.sv
module sos_round #(
    parameter int DATA_W  = 16,
    parameter int SCALE_W = 16,
    parameter int FRAC    = 15,
    parameter int R_W     = DATA_W + SCALE_W + 1 - FRAC
) (
    input  logic signed [DATA_W-1:0]  x_in,
    input  logic signed [SCALE_W-1:0] scale_in,
    output logic signed [R_W-1:0]     rounded
);
    localparam int P_W  = DATA_W + SCALE_W;
    localparam int PB_W = P_W + 1;

    logic signed [P_W-1:0]  x_ext;
    logic signed [P_W-1:0]  s_ext;
    logic signed [P_W-1:0]  prod;
    logic signed [PB_W-1:0] prod_ext;
    logic signed [PB_W-1:0] biased;

    assign x_ext    = {{SCALE_W{x_in[DATA_W-1]}}, x_in};
    assign s_ext    = {{DATA_W{scale_in[SCALE_W-1]}}, scale_in};
    assign prod     = x_ext * s_ext;
    assign prod_ext = {prod[P_W-1], prod};

    generate
        if (FRAC == 0) begin : g_no_round
            assign biased = prod_ext;
        end else begin : g_round
            localparam logic [PB_W-1:0] HALF = PB_W'(1) << (FRAC - 1);
            assign biased = prod_ext + HALF;
        end
    endgenerate

    assign rounded = biased[PB_W-1:FRAC];
endmodule

// File: rtl/sos_clip.sv
module sos_clip
    import sos_pkg::*;
#(
    parameter int R_W    = 19,
    parameter int OFF_W  = 16,
    parameter int SUM_W  = 20,
    parameter int DATA_W = 16
) (
    input  logic signed [R_W-1:0]    rounded,
    input  logic signed [OFF_W-1:0]  offset_in,
    output logic signed [DATA_W-1:0] clipped,
    output sat_kind_e                sat_kind
);
    localparam int HEAD = SUM_W - DATA_W + 1;
    localparam logic signed [SUM_W-1:0] MAXV = {{HEAD{1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MINV = {{HEAD{1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [SUM_W-1:0] r_ext;
    logic signed [SUM_W-1:0] o_ext;
    logic signed [SUM_W-1:0] sum;

    assign r_ext = {{(SUM_W-R_W){rounded[R_W-1]}}, rounded};
    assign o_ext = {{(SUM_W-OFF_W){offset_in[OFF_W-1]}}, offset_in};
    assign sum   = r_ext + o_ext;

    always_comb begin
        if (sum > MAXV) begin
            sat_kind = SAT_HI;
            clipped  = MAXV[DATA_W-1:0];
        end else if (sum < MINV) begin
            sat_kind = SAT_LO;
            clipped  = MINV[DATA_W-1:0];
        end else begin
            sat_kind = SAT_NONE;
            clipped  = sum[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/scale_offset_sat.sv
module scale_offset_sat
    import sos_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SCALE_W = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic signed [DATA_W-1:0]  x_in,
    input  logic signed [SCALE_W-1:0] scale_in,
    input  logic signed [OFF_W-1:0]   offset_in,
    output logic signed [DATA_W-1:0]  z_out,
    output logic                      out_valid
);
    localparam int FRAC  = frac_bits(SCALE_W, SHIFT);
    localparam int R_W   = DATA_W + SCALE_W + 1 - FRAC;
    localparam int SUM_W = sum_width(R_W, OFF_W);

    logic signed [R_W-1:0]    rounded;
    logic signed [DATA_W-1:0] clipped;
    sat_kind_e                sat_kind;

    sos_round #(
        .DATA_W (DATA_W),
        .SCALE_W(SCALE_W),
        .FRAC   (FRAC),
        .R_W    (R_W)
    ) u_round (
        .x_in    (x_in),
        .scale_in(scale_in),
        .rounded (rounded)
    );

    sos_clip #(
        .R_W   (R_W),
        .OFF_W (OFF_W),
        .SUM_W (SUM_W),
        .DATA_W(DATA_W)
    ) u_clip (
        .rounded  (rounded),
        .offset_in(offset_in),
        .clipped  (clipped),
        .sat_kind (sat_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            z_out     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                z_out <= clipped;
            end
        end
    end
endmodule

// File: rtl/sos_chk.sv
module sos_chk
    import sos_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] z_out,
    input logic                     out_valid,
    input sat_kind_e                sat_kind
);
    localparam logic signed [DATA_W-1:0] ZMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] ZMIN = {1'b1, {(DATA_W-1){1'b0}}};

    // R8
    reset_clears_chk: assert property (@(posedge clk) rst |=> (z_out == '0 && !out_valid));

    // R6
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

    // R6
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(z_out));

    // R3
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_kind == SAT_HI) |=> z_out == ZMAX);

    // R4
    sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_kind == SAT_LO) |=> z_out == ZMIN);
endmodule

bind scale_offset_sat sos_chk #(.DATA_W(DATA_W)) u_sos_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .z_out    (z_out),
    .out_valid(out_valid),
    .sat_kind (sat_kind)
);

// File: tb/tb_scale_offset_sat.sv
module tb_scale_offset_sat;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] x_in = '0;
    logic signed [15:0] scale_in = '0;
    logic signed [15:0] offset_in = '0;
    logic signed [15:0] z_out, z4;
    logic               out_valid, v4;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scale_offset_sat dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_in(x_in), .scale_in(scale_in), .offset_in(offset_in),
        .z_out(z_out), .out_valid(out_valid)
    );

    scale_offset_sat #(.SHIFT(4)) dut_n4 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_in(x_in), .scale_in(scale_in), .offset_in(offset_in),
        .z_out(z4), .out_valid(v4)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Drive one sample at a falling edge; the result is read one falling edge later
    task automatic apply(input int x, input int s, input int o);
        @(negedge clk);
        x_in      = 16'(x);
        scale_in  = 16'(s);
        offset_in = 16'(o);
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R8 z after reset", int'(z_out), 0);
        check("R8 valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_basic();
        apply(16384, 16384, 0);
        check("R1 half*half", int'(z_out), 8192);
        apply(1000, -16384, 7);
        check("R1 negative scale plus offset", int'(z_out), -493);
        apply(32767, -32768, 0);
        check("R1 minus one scale", int'(z_out), -32767);
    endtask

    task automatic t_round();
        apply(1, 16384, 0);
        check("R2 +0.5 rounds up", int'(z_out), 1);
        apply(-1, 16384, 0);
        check("R2 -0.5 rounds up", int'(z_out), 0);
        apply(-3, 16384, 0);
        check("R2 -1.5 rounds up", int'(z_out), -1);
        apply(1, 8191, 0);
        check("R2 below half dropped", int'(z_out), 0);
    endtask

    task automatic t_sat_high();
        apply(-32768, -32768, 0);
        check("R3 minus one squared", int'(z_out), 32767);
        apply(30000, 32767, 5000);
        check("R3 offset overflow", int'(z_out), 32767);
    endtask

    task automatic t_sat_low();
        apply(-30000, 32767, -5000);
        check("R4 offset underflow", int'(z_out), -32768);
        apply(32767, -32768, -1);
        check("R4 exact minimum passes", int'(z_out), -32768);
        apply(32767, -32768, -2);
        check("R4 just below minimum", int'(z_out), -32768);
    endtask

    task automatic t_offset();
        apply(0, 12345, -123);
        check("R5 offset only", int'(z_out), -123);
        apply(0, 0, 32767);
        check("R5 offset max", int'(z_out), 32767);
    endtask

    task automatic t_latency_hold();
        @(negedge clk);
        x_in = 16'sd2000; scale_in = 16'sd16384; offset_in = 16'sd1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 valid one cycle later", int'(out_valid), 1);
        check("R6 result one cycle later", int'(z_out), 1001);
        x_in = 16'sd9; scale_in = 16'sd32767; offset_in = 16'sd99;
        @(negedge clk);
        check("R6 valid drops", int'(out_valid), 0);
        check("R7 hold while idle", int'(z_out), 1001);
        x_in = -16'sd500;
        @(negedge clk);
        check("R7 hold second idle", int'(z_out), 1001);
    endtask

    task automatic t_shift();
        apply(100, 2048, 0);
        check("R9 n4 unity scale", int'(z4), 100);
        check("R9 n0 same codes", int'(z_out), 6);
        apply(1000, 32767, 0);
        check("R9 n4 near sixteen", int'(z4), 16000);
        apply(-3000, -32768, 0);
        check("R9 n4 saturates", int'(z4), 32767);
    endtask

    task automatic t_reset_mid();
        apply(5000, 32767, 0);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R8 sync reset z", int'(z_out), 0);
        check("R8 sync reset valid", int'(out_valid), 0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_basic();
        t_round();
        t_sat_high();
        t_sat_low();
        t_offset();
        t_latency_hold();
        t_shift();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule